// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is a small processor datapath in which the accumulator (AC), the memory address register (MAR), the memory buffer register (MBR), an instruction address register (IR), and two ALU staging registers (Y and Z) all meet on one shared internal bus. Each register has its own gate for driving the bus and its own gate for loading from it. Y holds the ALU's second operand and Z captures the ALU result, because the bus can carry only one value per step.

A built-in sequencer starts on a `start` pulse. It runs a fixed five-step transfer sequence that combines a memory word with the accumulator. Step 1 moves the address field from IR into MAR. Step 2 reads memory into MBR. Step 3 copies MBR to Y. Step 4 puts AC on the bus, applies the ALU and captures the result in Z. Step 5 writes Z back to AC. A two-bit operation code selects the ALU function used in step 4. The bus gates, the ALU select and the memory read strobe are brought out as ports, so the control activity of each step is visible.

Top module: `sbus_acc_dp`

## Requirements
- R1: After reset, `ac`, `mar` and `mbr` are zero, `busy` and `done` are low, and `drive_en`, `load_en`, `mem_rd` and `alu_fn` are all zero.
- R2: A `start` pulse while idle captures `instr_addr` and `opsel` and begins step 1. During step 1, `drive_en` is 4'b0100 (IR) and `load_en` is 4'b0010 (MAR). From step 2 onward, `mar` equals the captured address.
- R3: `mem_rd` is high only in step 2, during which `mem_addr` equals `mar`. `mbr` takes `mem_rdata` on the clock edge that ends step 2.
- R4: In every cycle at most one `drive_en` bit is set. The bit order is AC=bit0, MBR=bit1, IR=bit2, Z=bit3, and for `load_en` it is AC=bit0, MAR=bit1, Y=bit2, Z=bit3. Step 3 drives MBR and loads Y. Step 4 drives AC and loads Z, with `alu_fn` showing the effective code. Step 5 drives Z and loads AC. In idle and in step 2, both vectors are zero.
- R5: With `opsel` 2'b00 (add), the new AC is the old AC plus the memory word, modulo 2^W.
- R6: With `opsel` 2'b01 (pass), the new AC equals the memory word.
- R7: With `opsel` 2'b10 (increment), the new AC is the old AC plus 1, modulo 2^W. The memory word has no effect on AC, although it is still read into MBR.
- R8: `opsel` 2'b11 behaves exactly as add, and `alu_fn` shows 2'b00 in step 4.
- R9: `busy` is high for exactly the five step cycles. `done` is high for one cycle, in the cycle that follows step 5, and AC already holds the new value in that cycle.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the sequence in progress or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| opsel | input | 2 | ALU operation: 00 add, 01 pass, 10 increment, 11 add |
| instr_addr | input | AW | Address field loaded into IR on start |
| mem_rdata | input | W | Memory read data |
| mem_addr | output | AW | Memory address (MAR) |
| mem_rd | output | 1 | Memory read strobe |
| drive_en | output | 4 | Bus-out gates {Z, IR, MBR, AC} |
| load_en | output | 4 | Bus-in gates {Z, Y, MAR, AC} |
| alu_fn | output | 2 | ALU function in effect during step 4 |
| ac | output | W | Accumulator |
| mar | output | AW | Memory address register |
| mbr | output | W | Memory buffer register |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its defaults, W=16 and AW=8, so a 256-word memory model covers the whole address space, including the top address 8'hFF. Sixteen-bit data makes wraparound easy to reach: an add of 16'hFFFF and an increment from 16'hFFFF both wrap within a few sequences. Because AC carries over from one sequence to the next, a chain of operations checks the add, pass and increment functions against a running expected value. A stray start in mid-sequence checks that the sequence in progress is left unchanged.

// File: rtl/sbus_acc_dp.sv
module sbus_acc_dp #(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    opsel,
  input  logic [AW-1:0] instr_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic [3:0]    drive_en,
  output logic [3:0]    load_en,
  output logic [1:0]    alu_fn,
  output logic [W-1:0]  ac,
  output logic [AW-1:0] mar,
  output logic [W-1:0]  mbr,
  output logic          busy,
  output logic          done
);
  localparam logic [1:0] FN_ADD  = 2'b00;
  localparam logic [1:0] FN_PASS = 2'b01;
  localparam logic [1:0] FN_INC  = 2'b10;

  typedef enum logic [2:0] {IDLE, ST1, ST2, ST3, ST4, ST5} step_t;
  step_t       step;
  logic [AW-1:0] ir;
  logic [1:0]  op;
  logic [W-1:0] y, z, bus, alu_out;

  assign busy     = (step != IDLE);
  assign mem_addr = mar;
  assign mem_rd   = (step == ST2);

  always_comb begin
    drive_en = 4'b0000;
    load_en  = 4'b0000;
    alu_fn   = 2'b00;
    case (step)
      ST1: begin drive_en = 4'b0100; load_en = 4'b0010; end
      ST3: begin drive_en = 4'b0010; load_en = 4'b0100; end
      ST4: begin drive_en = 4'b0001; load_en = 4'b1000; alu_fn = op; end
      ST5: begin drive_en = 4'b1000; load_en = 4'b0001; end
      default: ;
    endcase
  end

  assign bus = ({W{drive_en[0]}} & ac)
             | ({W{drive_en[1]}} & mbr)
             | ({W{drive_en[2]}} & {{(W-AW){1'b0}}, ir})
             | ({W{drive_en[3]}} & z);

  always_comb begin
    case (alu_fn)
      FN_PASS: alu_out = y;
      FN_INC:  alu_out = bus + {{(W-1){1'b0}}, 1'b1};
      default: alu_out = bus + y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= IDLE;
      ir   <= '0;
      op   <= FN_ADD;
      done <= 1'b0;
    end else begin
      done <= (step == ST5);
      case (step)
        IDLE: if (start) begin
          ir   <= instr_addr;
          op   <= (opsel == 2'b11) ? FN_ADD : opsel;
          step <= ST1;
        end
        ST1: step <= ST2;
        ST2: step <= ST3;
        ST3: step <= ST4;
        ST4: step <= ST5;
        default: step <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac  <= '0;
      mar <= '0;
      mbr <= '0;
      y   <= '0;
      z   <= '0;
    end else begin
      if (load_en[0]) ac  <= bus;
      if (load_en[1]) mar <= bus[AW-1:0];
      if (load_en[2]) y   <= bus;
      if (load_en[3]) z   <= alu_out;
      if (mem_rd)     mbr <= mem_rdata;
    end
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_en)); // R4
  AST_MBR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mbr == $past(mem_rdata))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_AC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en[0] |=> $stable(ac)); // R5
  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (load_en == 4'b0010)); // R2
endmodule

// File: tb/sbus_acc_dp_tb.sv
`timescale 1ns/1ps
module sbus_acc_dp_tb;
  localparam int W = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] opsel = 2'b00;
  logic [AW-1:0] instr_addr = '0;
  logic [W-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_rd, busy, done;
  logic [3:0] drive_en, load_en;
  logic [1:0] alu_fn;
  logic [W-1:0] ac, mbr;
  logic [AW-1:0] mar;

  logic [W-1:0] mem [256];
  logic [W+AW+W-1:0] sb_q [$];
  logic [W-1:0] exp_ac = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  sbus_acc_dp #(.W(W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opsel(opsel),
    .instr_addr(instr_addr), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .drive_en(drive_en), .load_en(load_en),
    .alu_fn(alu_fn), .ac(ac), .mar(mar), .mbr(mbr), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops an expected item whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk("R9 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [W+AW+W-1:0] it;
        it = sb_q.pop_front();
        chk("R5-R8 ac result", 32'(ac), 32'(it[W+AW+W-1:AW+W]));
        chk("R2 mar", 32'(mar), 32'(it[AW+W-1:W]));
        chk("R3 mbr", 32'(mbr), 32'(it[W-1:0]));
      end
    end
  end

  // driver: runs one sequence, checks step controls, pushes expected result
  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input bit stray);
    logic [W-1:0] m;
    m = mem[a];
    case (op)
      2'b01: exp_ac = m;
      2'b10: exp_ac = exp_ac + 16'd1;
      default: exp_ac = exp_ac + m;
    endcase
    sb_q.push_back({exp_ac, a, m});
    @(negedge clk);
    start = 1'b1; opsel = op; instr_addr = a;
    @(negedge clk);
    start = 1'b0; opsel = ~op; instr_addr = ~a;
    chk("R2 step1 drive", 32'(drive_en), 32'h4);
    chk("R2 step1 load", 32'(load_en), 32'h2);
    chk("R9 busy step1", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R3 rd step2", 32'(mem_rd), 32'd1);
    chk("R3 addr step2", 32'(mem_addr), 32'(a));
    chk("R4 gates step2", 32'({drive_en, load_en}), 32'h0);
    if (stray) begin start = 1'b1; opsel = 2'b01; instr_addr = a + 8'd1; end
    @(negedge clk);
    start = 1'b0;
    chk("R3 rd low step3", 32'(mem_rd), 32'd0);
    chk("R4 step3 gates", 32'({drive_en, load_en}), 32'h24);
    @(negedge clk);
    chk("R4 step4 gates", 32'({drive_en, load_en}), 32'h18);
    chk("R8 alu_fn step4", 32'(alu_fn), (op == 2'b11) ? 32'd0 : 32'(op));
    @(negedge clk);
    chk("R4 step5 gates", 32'({drive_en, load_en}), 32'h81);
    chk("R9 busy step5", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R9 done", 32'(done), 32'd1);
    chk("R9 idle busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R10 no restart", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
    mem[255] = 16'hFFFF;
    mem[0]   = 16'h0001;
    repeat (3) @(negedge clk);
    chk("R1 ac", 32'(ac), 32'd0);
    chk("R1 mar", 32'(mar), 32'd0);
    chk("R1 mbr", 32'(mbr), 32'd0);
    chk("R1 flags", 32'({busy, done, mem_rd, alu_fn, drive_en, load_en}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle gates", 32'({busy, drive_en, load_en}), 32'd0);
    run_op(2'b00, 8'd3, 0);    // R5 add
    run_op(2'b00, 8'hFF, 0);   // R5 add with wrap
    run_op(2'b01, 8'd10, 0);   // R6 pass
    run_op(2'b10, 8'd40, 0);   // R7 increment ignores operand
    run_op(2'b11, 8'd0, 0);    // R8 code 11 as add
    run_op(2'b00, 8'd77, 1);   // R10 stray start mid-sequence
    run_op(2'b01, 8'hFF, 0);   // R6 load FFFF
    run_op(2'b10, 8'd5, 0);    // R7 increment wraps to 0
    chk("R7 wrap to zero", 32'(ac), 32'd0);
    repeat (4) @(negedge clk);
    chk("R9 queue drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule